// File: doc/BRIEF.md
# Bank Extension Controller for an 8-bit CPU

This block sits next to an 8-bit CPU core with a 16-bit address bus and supplies the extra high address bits that widen its reach beyond 64 KB. It holds two bank registers. The code bank is used for almost every bus cycle. The data bank is used only for the operand access of the two indirect-indexed memory instructions: the load with opcode $B1 and the store with opcode $91.

The block watches the CPU bus on every clock: address, data, read/write, the opcode-fetch strobe and the ready line. From these it decides, cycle by cycle, which bank drives the extra address outputs.

- Software writes the two registers through CPU locations $0000 and $0001, which are present in every bank.
- The block counts bus cycles from the opcode fetch to reach the data-access cycles of the two instructions.
- Cycles in which a stalled read holds the CPU are not counted.
- If address bit 0 does not change after the fetch, the fetch is a false one made at interrupt entry, and the block drops the sequence.

Top module: `bank_ext_ctrl`

## Requirements
- R1: A write cycle (`cpu_rw`=0) to address $0000 loads the code bank, and one to $0001 loads the data bank, from the low BANK_W bits of `cpu_data`. The write takes effect on the clock edge that ends the cycle, whether or not `cpu_rdy` is high.
- R2: A read cycle to $0000 or $0001 raises `reg_rd_en`, and `reg_rd_data` returns the matching register in its low bits with the upper bits zero. Any other address keeps `reg_rd_en` low.
- R3: After reset, both registers hold all ones, and `bank_out` shows the code bank, all ones.
- R4: After a write to $0000, `bank_out` carries the new code bank from the very next bus cycle onward.
- R5: A completed fetch cycle (`cpu_sync`=1) with `cpu_data` equal to $91 or $B1 arms a sequence. The opcode fetch is cycle 1 of the instruction. `bank_out` shows the data bank in cycle 5, and also in cycle 6 when `cpu_sync` is low in that cycle.
- R6: Fetched opcodes other than exactly $91 and $B1, including $93 and $B3, never select the data bank.
- R7: If `cpu_sync` is high in cycle 6 (a load with no page crossing), `bank_out` shows the code bank in that cycle.
- R8: If address bit 0 in cycle 2 equals address bit 0 of the fetch cycle, the sequence is cancelled and the data bank is not used.
- R9: A read cycle with `cpu_rdy` low is not counted, so the data-bank window keeps its position in completed cycles.
- R10: All cycles outside the cycle 5/6 window, including cycle 7 onward, use the code bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; each rising edge ends a bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | Data bus as observed (fetched opcode or write data) |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_sync | input | 1 | High during an opcode fetch cycle |
| cpu_rdy | input | 1 | Low stalls a read cycle |
| bank_out | output | BANK_W | Extra high address bits for the current cycle |
| reg_rd_data | output | 8 | Register read value for $0000/$0001 |
| reg_rd_en | output | 1 | High when a read targets a bank register |

## Verification
Register writes and fetch decodes act on the edge that ends their cycle, so their effect on `bank_out` is due in the cycle that follows. Register read data, and the `cpu_sync` override in cycle 6, depend only on the current cycle. For every bus cycle the driver queues the bank expected for that same cycle. The monitor compares it on the falling clock edge, after the inputs have settled and before the edge that ends the cycle. Stalled cycles are queued one by one, so the window is checked against completed cycles rather than raw clock counts.

// File: rtl/bank_ext_pkg.sv
// Package: shared constants for the bank extension controller.
// Assumes an 8-bit data bus and a 16-bit CPU address bus.
package bank_ext_pkg;
    localparam logic [7:0]  OP_LOAD_IIX  = 8'hB1;
    localparam logic [7:0]  OP_STORE_IIX = 8'h91;
    localparam logic [15:0] ADDR_CODE_BANK = 16'h0000;
    localparam logic [15:0] ADDR_DATA_BANK = 16'h0001;
    localparam int          SEQ_W = 3;
endpackage

// File: rtl/bank_ext_regs.sv
// Module: the code-bank and data-bank registers, with their read path.
// Writes are honoured whatever the state of RDY; the read value is combinational.
module bank_ext_regs
    import bank_ext_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    output logic [BANK_W-1:0] code_bank,
    output logic [BANK_W-1:0] data_bank,
    output logic [7:0]        rd_data,
    output logic              rd_en
);
    localparam int PAD_W = 8 - BANK_W;

    logic hit_code, hit_data;
    assign hit_code = (cpu_addr == ADDR_CODE_BANK);
    assign hit_data = (cpu_addr == ADDR_DATA_BANK);

    // Purpose: load the registers on write cycles to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_bank <= '1;
            data_bank <= '1;
        end else if (!cpu_rw) begin
            if (hit_code) code_bank <= cpu_data[BANK_W-1:0];
            if (hit_data) data_bank <= cpu_data[BANK_W-1:0];
        end
    end

    // Purpose: return the addressed register, zero-extended, on read cycles.
    always_comb begin
        rd_en   = cpu_rw && (hit_code || hit_data);
        rd_data = '0;
        if (cpu_rw && hit_code) rd_data = {{PAD_W{1'b0}}, code_bank};
        if (cpu_rw && hit_data) rd_data = {{PAD_W{1'b0}}, data_bank};
    end

    // R1: a write to $0000 is visible in the code bank on the next cycle
    a_r1_code_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rw && hit_code) |=> (code_bank == $past(cpu_data[BANK_W-1:0])));
    // R1: a write to $0001 is visible in the data bank on the next cycle
    a_r1_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rw && hit_data) |=> (data_bank == $past(cpu_data[BANK_W-1:0])));
    // R2: a write cycle never drives the read path
    a_r2_no_read_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> !rd_en);
endmodule

// File: rtl/bank_ext_seq.sv
// Module: tracks the indirect-indexed load/store through its bus cycles.
// seq_cnt counts the completed cycles of an armed instruction (0 = idle).
// A cycle completes when RDY is high or when it is a write cycle.
// A false fetch at interrupt entry is detected when A0 does not toggle in cycle 2.
module bank_ext_seq
    import bank_ext_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_lsb,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_rw,
    input  logic        cpu_sync,
    input  logic        cpu_rdy,
    output logic        use_data_bank
);
    logic [SEQ_W-1:0] seq_cnt;
    logic             fetch_lsb;
    logic             advance, is_target;

    assign advance   = cpu_rdy || !cpu_rw;
    assign is_target = (cpu_data == OP_LOAD_IIX) || (cpu_data == OP_STORE_IIX);

    // Purpose: step the cycle counter on each completed bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_cnt   <= '0;
            fetch_lsb <= 1'b0;
        end else if (advance) begin
            if (cpu_sync) begin
                seq_cnt   <= is_target ? SEQ_W'(1) : '0;
                fetch_lsb <= addr_lsb;
            end else begin
                case (seq_cnt)
                    SEQ_W'(1): seq_cnt <= (addr_lsb == fetch_lsb) ? '0 : SEQ_W'(2);
                    SEQ_W'(2), SEQ_W'(3), SEQ_W'(4): seq_cnt <= seq_cnt + SEQ_W'(1);
                    default:   seq_cnt <= '0;
                endcase
            end
        end
    end

    // Purpose: mark cycles 5 and 6 of the armed instruction.
    assign use_data_bank = (seq_cnt == SEQ_W'(4)) || (seq_cnt == SEQ_W'(5));

    // R9: a stalled read cycle freezes the sequence position
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance) |=> $stable(seq_cnt));
    // R8: no A0 toggle after the fetch drops the armed sequence
    a_r8_false_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_cnt == SEQ_W'(1) && advance && !cpu_sync && addr_lsb == fetch_lsb)
        |=> !use_data_bank && seq_cnt == '0);
    // R10: the counter never leaves its legal range
    a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cnt <= SEQ_W'(5));
endmodule

// File: rtl/bank_ext_ctrl.sv
// Module: top of the bank extension controller.
// Picks the code or data bank for each bus cycle. The bank choice is registered,
// and a fetch cycle (SYNC high) always forces the code bank.
module bank_ext_ctrl
    import bank_ext_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    input  logic              cpu_sync,
    input  logic              cpu_rdy,
    output logic [BANK_W-1:0] bank_out,
    output logic [7:0]        reg_rd_data,
    output logic              reg_rd_en
);
    logic [BANK_W-1:0] code_bank, data_bank;
    logic              use_data_bank;

    bank_ext_regs #(.BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .code_bank(code_bank), .data_bank(data_bank),
        .rd_data(reg_rd_data), .rd_en(reg_rd_en)
    );

    bank_ext_seq u_seq (
        .clk(clk), .rst_n(rst_n), .addr_lsb(cpu_addr[0]), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_sync(cpu_sync), .cpu_rdy(cpu_rdy),
        .use_data_bank(use_data_bank)
    );

    // Purpose: select the bank for this cycle; a fetch always uses the code bank.
    assign bank_out = (use_data_bank && !cpu_sync) ? data_bank : code_bank;

    // R7: an opcode fetch never sees a data bank that differs from the code bank
    a_r7_fetch_code_bank: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sync |-> (bank_out == code_bank));
    // R5: the bank output is always one of the two registers
    a_r5_bank_source: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_out == code_bank) || (bank_out == data_bank));
endmodule

// File: tb/bank_ext_ctrl_bench.sv
`timescale 1ns/100ps
module bank_ext_ctrl_bench;
    localparam int BANK_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_data = '0;
    logic              cpu_rw = 1'b1;
    logic              cpu_sync = 1'b0;
    logic              cpu_rdy = 1'b1;
    logic [BANK_W-1:0] bank_out;
    logic [7:0]        reg_rd_data;
    logic              reg_rd_en;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [BANK_W-1:0] bank;
        bit                chk_rd;
        logic              rd_en;
        logic [7:0]        rd_data;
        string             req;
    } exp_t;
    exp_t sb[$];

    logic [BANK_W-1:0] m_code = '1;
    logic [BANK_W-1:0] m_data = '1;

    always #2 clk = ~clk;

    bank_ext_ctrl #(.BANK_W(BANK_W)) u_bank_ext_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_sync(cpu_sync), .cpu_rdy(cpu_rdy),
        .bank_out(bank_out), .reg_rd_data(reg_rd_data), .reg_rd_en(reg_rd_en)
    );

    // Drive one bus cycle and queue the bank expected during it.
    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic rw,
                       input logic sy, input logic rd, input bit ind, input string req);
        exp_t e;
        @(posedge clk); #0.5;
        cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_sync = sy; cpu_rdy = rd;
        e.bank = ind ? m_data : m_code;
        e.chk_rd = 1'b0; e.rd_en = 1'b0; e.rd_data = '0; e.req = req;
        sb.push_back(e);
        if (!rw && a == 16'h0000) m_code = d[BANK_W-1:0];
        if (!rw && a == 16'h0001) m_data = d[BANK_W-1:0];
    endtask

    // Drive a register read and queue the expected read data as well.
    task automatic rd_cyc(input logic [15:0] a, input string req);
        exp_t e;
        @(posedge clk); #0.5;
        cpu_addr = a; cpu_data = 8'hEA; cpu_rw = 1'b1; cpu_sync = 1'b0; cpu_rdy = 1'b1;
        e.bank = m_code; e.chk_rd = 1'b1; e.req = req;
        e.rd_en = (a == 16'h0000) || (a == 16'h0001);
        e.rd_data = (a == 16'h0000) ? {4'h0, m_code} : (a == 16'h0001) ? {4'h0, m_data} : 8'h00;
        sb.push_back(e);
    endtask

    // Monitor: compare each queued item in the middle of its cycle.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (bank_out !== e.bank) begin
                bad++;
                $display("FAIL %s bank_out actual=%h expected=%h", e.req, bank_out, e.bank);
            end
            if (e.chk_rd) begin
                total++;
                if (reg_rd_en !== e.rd_en || (e.rd_en && reg_rd_data !== e.rd_data)) begin
                    bad++;
                    $display("FAIL %s read actual=%b/%h expected=%b/%h", e.req,
                             reg_rd_en, reg_rd_data, e.rd_en, e.rd_data);
                end
            end
        end
    end

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        // R3: reset state, registers read back as all ones
        rd_cyc(16'h0000, "R3");
        rd_cyc(16'h0001, "R3");
        // R2: other address does not hit the registers
        rd_cyc(16'h0002, "R2");
        // R1/R4: write code bank (with rdy low) and data bank
        cyc(16'h0000, 8'hF2, 1'b0, 1'b0, 1'b0, 0, "R1");
        cyc(16'h1000, 8'hEA, 1'b1, 1'b1, 1'b1, 0, "R4");
        cyc(16'h0001, 8'h3A, 1'b0, 1'b0, 1'b1, 0, "R1");
        rd_cyc(16'h0000, "R2");
        rd_cyc(16'h0001, "R2");
        // R5: load with page crossing, cycles 5 and 6 use data bank, R10 cycle 7 code
        cyc(16'h0200, 8'hB1, 1'b1, 1'b1, 1'b1, 0, "R5");
        cyc(16'h0201, 8'h10, 1'b1, 1'b0, 1'b1, 0, "R5");
        cyc(16'h0010, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R5");
        cyc(16'h0011, 8'h40, 1'b1, 1'b0, 1'b1, 0, "R5");
        cyc(16'h40F0, 8'h55, 1'b1, 1'b0, 1'b1, 1, "R5");
        cyc(16'h4100, 8'h55, 1'b1, 1'b0, 1'b1, 1, "R5");
        cyc(16'h0202, 8'hEA, 1'b1, 1'b1, 1'b1, 0, "R10");
        cyc(16'h0203, 8'hEA, 1'b1, 1'b0, 1'b1, 0, "R10");
        // R7: load without page crossing, cycle 6 is a fetch
        cyc(16'h0300, 8'hB1, 1'b1, 1'b1, 1'b1, 0, "R7");
        cyc(16'h0301, 8'h10, 1'b1, 1'b0, 1'b1, 0, "R7");
        cyc(16'h0010, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R7");
        cyc(16'h0011, 8'h40, 1'b1, 1'b0, 1'b1, 0, "R7");
        cyc(16'h4005, 8'h55, 1'b1, 1'b0, 1'b1, 1, "R7");
        cyc(16'h0302, 8'hEA, 1'b1, 1'b1, 1'b1, 0, "R7");
        cyc(16'h0303, 8'hEA, 1'b1, 1'b0, 1'b1, 0, "R7");
        // R5: store, both cycle 5 and 6 in data bank
        cyc(16'h0401, 8'h91, 1'b1, 1'b1, 1'b1, 0, "R5");
        cyc(16'h0402, 8'h20, 1'b1, 1'b0, 1'b1, 0, "R5");
        cyc(16'h0020, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R5");
        cyc(16'h0021, 8'h50, 1'b1, 1'b0, 1'b1, 0, "R5");
        cyc(16'h5003, 8'h00, 1'b1, 1'b0, 1'b1, 1, "R5");
        cyc(16'h5003, 8'h77, 1'b0, 1'b0, 1'b1, 1, "R5");
        cyc(16'h0403, 8'hEA, 1'b1, 1'b1, 1'b1, 0, "R10");
        // R6: $93 and $B3 do not trigger
        for (int k = 0; k < 2; k++) begin
            cyc(16'h0500, k == 0 ? 8'h93 : 8'hB3, 1'b1, 1'b1, 1'b1, 0, "R6");
            cyc(16'h0501, 8'h10, 1'b1, 1'b0, 1'b1, 0, "R6");
            cyc(16'h0010, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R6");
            cyc(16'h0011, 8'h40, 1'b1, 1'b0, 1'b1, 0, "R6");
            cyc(16'h40F0, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R6");
            cyc(16'h4100, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R6");
        end
        // R8: false fetch at interrupt entry, A0 does not toggle
        cyc(16'h0601, 8'hB1, 1'b1, 1'b1, 1'b1, 0, "R8");
        cyc(16'h0601, 8'hB1, 1'b1, 1'b0, 1'b1, 0, "R8");
        cyc(16'h01FF, 8'h06, 1'b0, 1'b0, 1'b1, 0, "R8");
        cyc(16'h01FE, 8'h01, 1'b0, 1'b0, 1'b1, 0, "R8");
        cyc(16'h01FD, 8'h30, 1'b0, 1'b0, 1'b1, 0, "R8");
        cyc(16'hFFFE, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R8");
        cyc(16'hFFFF, 8'h80, 1'b1, 1'b0, 1'b1, 0, "R8");
        // R9: stalled read cycles within the sequence are not counted
        cyc(16'h0700, 8'hB1, 1'b1, 1'b1, 1'b1, 0, "R9");
        cyc(16'h0701, 8'h10, 1'b1, 1'b0, 1'b1, 0, "R9");
        cyc(16'h0010, 8'h00, 1'b1, 1'b0, 1'b0, 0, "R9");
        cyc(16'h0010, 8'h00, 1'b1, 1'b0, 1'b0, 0, "R9");
        cyc(16'h0010, 8'h00, 1'b1, 1'b0, 1'b1, 0, "R9");
        cyc(16'h0011, 8'h40, 1'b1, 1'b0, 1'b1, 0, "R9");
        cyc(16'h40F0, 8'h00, 1'b1, 1'b0, 1'b0, 1, "R9");
        cyc(16'h40F0, 8'h00, 1'b1, 1'b0, 1'b1, 1, "R9");
        cyc(16'h4100, 8'h00, 1'b1, 1'b0, 1'b1, 1, "R9");
        cyc(16'h0702, 8'hEA, 1'b1, 1'b1, 1'b1, 0, "R10");
        // R4: a code-bank switch carries on from the next cycle
        cyc(16'h0000, 8'h07, 1'b0, 1'b0, 1'b1, 0, "R4");
        cyc(16'h0703, 8'hEA, 1'b1, 1'b1, 1'b1, 0, "R4");
        rd_cyc(16'h0000, "R4");
        @(posedge clk); @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule